// File: doc/BRIEF.md
# Move-Wide Immediate Execute Unit

This unit forms the result of the three move-wide-immediate operations of a 64-bit load/store core. It takes already-extracted instruction fields: an issue strobe, a width flag, a two-bit operation code, a two-bit lane selector, a 16-bit immediate and a destination index. It also takes the current value of the destination register, which the insert operation needs. It returns the value to write back, a write strobe, the destination index and an illegal-instruction flag.

The immediate is zero-extended and placed in one of four 16-bit lanes chosen by the selector. The unit then builds one of three results from it. Zero-fill writes the placed immediate with every other bit clear. Inverted-fill writes the bitwise complement of the placed immediate. Insert replaces only the selected lane of the current destination value. In narrow (32-bit) mode the result is cut to the low 32 bits, and lane selectors that point above bit 31 are rejected. Outputs are registered by default (parameter `OUT_REG`), so results appear one clock after issue.

Top module: `mw_exec`

## Requirements
- R1: The immediate is treated as unsigned and placed at bit position 16 × `in_lane` (selector 0..3 gives bit 0, 16, 32 or 48). No sign bits reach the other lanes.
- R2: Operation code 2'b10 (zero-fill) produces the placed immediate with all other bits 0.
- R3: Operation code 2'b00 (inverted-fill) produces the bitwise inverse of the placed immediate, so the other lanes read all ones in wide mode.
- R4: Operation code 2'b11 (insert) produces `in_cur` with only the selected 16-bit lane replaced by the immediate.
- R5: Operation code 2'b01 is illegal in both widths. It raises `out_illegal`, keeps `out_wen` low and drives `out_value` to 0.
- R6: With `in_wide` = 0, a lane selector whose upper bit is set (2 or 3) is illegal. It raises `out_illegal`, keeps `out_wen` low and drives `out_value` to 0.
- R7: With `in_wide` = 0, the result is masked to the low 32 bits, and bits 63:32 are 0 for every operation, inverted-fill and insert included.
- R8: `out_wen` and `out_illegal` are never high together. Both stay low for a cycle without `in_valid`.
- R9: With `OUT_REG` = 1, outputs change one clock after issue. A synchronous active-high reset clears every output to 0.
- R10: `out_dst` carries the destination index of the operation whose result is on `out_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is issued this cycle |
| in_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| in_opc | input | 2 | Operation code: 00 inverted-fill, 01 illegal, 10 zero-fill, 11 insert |
| in_lane | input | 2 | Lane selector: the immediate lands at bit 16 × in_lane |
| in_imm | input | 16 | Unsigned immediate |
| in_dst | input | 5 | Destination register index |
| in_cur | input | 64 | Current destination register value, used by insert |
| out_value | output | 64 | Result to write back |
| out_wen | output | 1 | Write strobe for a legal operation |
| out_dst | output | 5 | Destination index of the result |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
The embedded assertions check the following on every cycle, for any stimulus: write strobe and illegal flag are exclusive, an idle cycle leaves both low, operation code 01 and the narrow upper lanes always raise the flag, narrow results keep bits 63:32 clear, and insert leaves the bits outside the lane untouched. Which lane receives the immediate, what exact value zero-fill and inverted-fill produce, that no sign bits leak into the upper lanes, the destination tag and the reset values can only be shown by the bench. Its scenarios compare the outputs against values computed independently for all four lanes of each operation in both widths.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    MW_INVERT = 2'b00,
    MW_BAD    = 2'b01,
    MW_ZERO   = 2'b10,
    MW_KEEP   = 2'b11
  } mw_op_e;

  function automatic int unsigned lane_count(input int unsigned width,
                                             input int unsigned lane_w);
    return width / lane_w;
  endfunction

endpackage

// File: rtl/mw_decode.sv
module mw_decode #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 16,
  localparam int LANES    = DATA_W / IMM_W,
  localparam int SEL_W    = $clog2(LANES),
  localparam int NARROW_L = NARROW_W / IMM_W
) (
  input  logic             valid,
  input  logic             wide,
  input  logic [1:0]       opc,
  input  logic [SEL_W-1:0] lane,
  output mw_pkg::mw_op_e   op,
  output logic             legal_wen,
  output logic             illegal
);
  import mw_pkg::*;

  logic bad_code;
  logic bad_lane;

  always_comb begin
    op       = mw_op_e'(opc);
    bad_code = (op == MW_BAD);
    bad_lane = !wide && (int'(lane) >= NARROW_L);
    illegal  = valid && (bad_code || bad_lane);
    legal_wen = valid && !bad_code && !bad_lane;
  end

  always_comb begin
    if (valid) begin
      AST_DEC_EXCLUSIVE: assert (!(legal_wen && illegal)); // R8
    end
  end

endmodule

// File: rtl/mw_lane.sv
module mw_lane #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  localparam int LANES = DATA_W / IMM_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [SEL_W-1:0]  lane,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] placed,
  output logic [DATA_W-1:0] lane_mask
);

  logic [LANES-1:0] hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = (lane == SEL_W'(g));
    assign placed[g*IMM_W +: IMM_W]    = hit[g] ? imm : '0;
    assign lane_mask[g*IMM_W +: IMM_W] = {IMM_W{hit[g]}};
  end

  always_comb begin
    AST_ONE_LANE: assert ($onehot0(hit) && hit != '0); // R1
  end

endmodule

// File: rtl/mw_merge.sv
module mw_merge #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  mw_pkg::mw_op_e    op,
  input  logic              wide,
  input  logic              legal,
  input  logic [DATA_W-1:0] placed,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] result
);
  import mw_pkg::*;

  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (op)
      MW_INVERT: raw = ~placed;
      MW_ZERO:   raw = placed;
      MW_KEEP:   raw = (cur & ~lane_mask) | placed;
      default:   raw = '0;
    endcase
    if (!legal)     result = '0;
    else if (!wide) result = raw & LOW_MASK;
    else            result = raw;
  end

endmodule

// File: rtl/mw_outreg.sv
module mw_outreg #(
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_value,
  input  logic              d_wen,
  input  logic [IDX_W-1:0]  d_dst,
  input  logic              d_ill,
  output logic [DATA_W-1:0] q_value,
  output logic              q_wen,
  output logic [IDX_W-1:0]  q_dst,
  output logic              q_ill
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_value <= '0;
        q_wen   <= 1'b0;
        q_dst   <= '0;
        q_ill   <= 1'b0;
      end else begin
        q_value <= d_value;
        q_wen   <= d_wen;
        q_dst   <= d_dst;
        q_ill   <= d_ill;
      end
    end
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign q_value = d_value;
    assign q_wen   = d_wen;
    assign q_dst   = d_dst;
    assign q_ill   = d_ill;
  end

endmodule

// File: rtl/mw_exec.sv
module mw_exec #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 16,
  parameter int IDX_W    = 5,
  parameter bit OUT_REG  = 1'b1,
  localparam int LANES   = DATA_W / IMM_W,
  localparam int SEL_W   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [1:0]        in_opc,
  input  logic [SEL_W-1:0]  in_lane,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] in_cur,
  output logic [DATA_W-1:0] out_value,
  output logic              out_wen,
  output logic [IDX_W-1:0]  out_dst,
  output logic              out_illegal
);
  import mw_pkg::*;

  mw_op_e            op;
  logic              wen_c;
  logic              ill_c;
  logic [DATA_W-1:0] placed;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] result;

  mw_decode #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .IMM_W(IMM_W)) u_dec (
    .valid(in_valid), .wide(in_wide), .opc(in_opc), .lane(in_lane),
    .op(op), .legal_wen(wen_c), .illegal(ill_c)
  );

  mw_lane #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_lane (
    .lane(in_lane), .imm(in_imm), .placed(placed), .lane_mask(lane_mask)
  );

  mw_merge #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_merge (
    .op(op), .wide(in_wide), .legal(wen_c), .placed(placed),
    .lane_mask(lane_mask), .cur(in_cur), .result(result)
  );

  mw_outreg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst(rst),
    .d_value(result), .d_wen(wen_c), .d_dst(in_dst), .d_ill(ill_c),
    .q_value(out_value), .q_wen(out_wen), .q_dst(out_dst), .q_ill(out_illegal)
  );

  AST_WEN_ILL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_wen && out_illegal)); // R8

  if (OUT_REG) begin : g_chk
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!in_valid)) |-> (!out_wen && !out_illegal)); // R8
    AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_valid) && $past(in_opc) == 2'b01)
        |-> (out_illegal && !out_wen && out_value == '0)); // R5
    AST_NARROW_LANE: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_valid) && $past(!in_wide) && $past(in_lane[SEL_W-1]))
        |-> (out_illegal && !out_wen)); // R6
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_valid) && $past(!in_wide))
        |-> (out_value[DATA_W-1:NARROW_W] == '0)); // R7
    AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(in_valid) && $past(in_wide) && $past(in_opc) == 2'b11)
        |-> ((out_value & ~$past(lane_mask)) == ($past(in_cur) & ~$past(lane_mask)))); // R4
  end

endmodule

// File: tb/mw_exec_test.sv
module mw_exec_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_wide;
  logic [1:0]  in_opc;
  logic [1:0]  in_lane;
  logic [15:0] in_imm;
  logic [4:0]  in_dst;
  logic [63:0] in_cur;
  logic [63:0] out_value;
  logic        out_wen;
  logic [4:0]  out_dst;
  logic        out_illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mw_exec uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
    .in_opc(in_opc), .in_lane(in_lane), .in_imm(in_imm), .in_dst(in_dst),
    .in_cur(in_cur), .out_value(out_value), .out_wen(out_wen),
    .out_dst(out_dst), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] model(input logic wide, input logic [1:0] opc,
                                        input logic [1:0] lane, input logic [15:0] imm,
                                        input logic [63:0] cur);
    logic [63:0] sh, m, r;
    sh = {48'h0, imm} << (16 * int'(lane));
    m  = 64'hFFFF << (16 * int'(lane));
    case (opc)
      2'b00:   r = ~sh;
      2'b10:   r = sh;
      2'b11:   r = (cur & ~m) | sh;
      default: r = 64'h0;
    endcase
    if (!wide) r = r & 64'h0000_0000_FFFF_FFFF;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic v, input logic wide, input logic [1:0] opc,
                       input logic [1:0] lane, input logic [15:0] imm,
                       input logic [4:0] dst, input logic [63:0] cur);
    @(negedge clk);
    in_valid = v; in_wide = wide; in_opc = opc; in_lane = lane;
    in_imm = imm; in_dst = dst; in_cur = cur;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_legal(input string req, input logic wide, input logic [1:0] opc,
                           input logic [1:0] lane, input logic [15:0] imm,
                           input logic [4:0] dst, input logic [63:0] cur);
    issue(1'b1, wide, opc, lane, imm, dst, cur);
    check(req, out_value, model(wide, opc, lane, imm, cur));
    check({req, "/wen"}, {63'h0, out_wen}, 64'h1);
    check({req, "/R8 ill"}, {63'h0, out_illegal}, 64'h0);
    check({req, "/R10 dst"}, {59'h0, out_dst}, {59'h0, dst});
  endtask

  task automatic run_illegal(input string req, input logic wide, input logic [1:0] opc,
                             input logic [1:0] lane);
    issue(1'b1, wide, opc, lane, 16'hBEEF, 5'd9, 64'hFFFF_FFFF_FFFF_FFFF);
    check({req, " ill"}, {63'h0, out_illegal}, 64'h1);
    check({req, " wen"}, {63'h0, out_wen}, 64'h0);
    check({req, " val"}, out_value, 64'h0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    issue(1'b1, 1'b1, 2'b10, 2'd3, 16'h1234, 5'd7, 64'h0);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset value", out_value, 64'h0);
    check("R9 reset wen", {63'h0, out_wen}, 64'h0);
    check("R9 reset ill", {63'h0, out_illegal}, 64'h0);
    check("R9 reset dst", {59'h0, out_dst}, 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_zero_fill();
    for (int l = 0; l < 4; l++)
      run_legal("R1 R2 zero-fill wide", 1'b1, 2'b10, 2'(l), 16'h8421 + 16'(l), 5'(l + 1),
                64'hDEAD_BEEF_CAFE_F00D);
  endtask

  task automatic t_sign_leak();
    run_legal("R1 unsigned imm", 1'b1, 2'b10, 2'd0, 16'hFFFF, 5'd2, 64'h0);
    check("R1 upper clear", {48'h0, out_value[63:16]}, 64'h0);
  endtask

  task automatic t_invert();
    for (int l = 0; l < 4; l++)
      run_legal("R3 inverted-fill wide", 1'b1, 2'b00, 2'(l), 16'h00F0 ^ 16'(l), 5'(l + 10),
                64'h0);
  endtask

  task automatic t_keep();
    for (int l = 0; l < 4; l++)
      run_legal("R4 insert wide", 1'b1, 2'b11, 2'(l), 16'h5A5A + 16'(l), 5'(l + 20),
                64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_narrow();
    for (int l = 0; l < 2; l++) begin
      run_legal("R7 narrow zero-fill", 1'b0, 2'b10, 2'(l), 16'hC3C3, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      run_legal("R7 narrow invert", 1'b0, 2'b00, 2'(l), 16'h0001, 5'd4, 64'h0);
      run_legal("R7 narrow insert", 1'b0, 2'b11, 2'(l), 16'h7777, 5'd5, 64'hAAAA_BBBB_CCCC_DDDD);
    end
  endtask

  task automatic t_illegal();
    run_illegal("R5 opc01 wide", 1'b1, 2'b01, 2'd2);
    run_illegal("R5 opc01 narrow", 1'b0, 2'b01, 2'd0);
    for (int l = 2; l < 4; l++) begin
      run_illegal("R6 narrow high lane zero", 1'b0, 2'b10, 2'(l));
      run_illegal("R6 narrow high lane keep", 1'b0, 2'b11, 2'(l));
      run_illegal("R6 narrow high lane inv", 1'b0, 2'b00, 2'(l));
    end
  endtask

  task automatic t_idle();
    issue(1'b0, 1'b1, 2'b10, 2'd1, 16'h1111, 5'd6, 64'h0);
    check("R8 idle wen", {63'h0, out_wen}, 64'h0);
    check("R8 idle ill", {63'h0, out_illegal}, 64'h0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1; in_wide = 1'b1; in_opc = 2'b10; in_lane = 2'd2;
    in_imm = 16'h4242; in_dst = 5'd31; in_cur = 64'h0;
    #1;
    check("R9 not yet", {63'h0, out_wen}, 64'h0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 one clock", out_value, 64'h0000_4242_0000_0000);
    check("R10 dst", {59'h0, out_dst}, 64'd31);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_wide = 1'b0; in_opc = 2'b00; in_lane = 2'd0;
    in_imm = '0; in_dst = '0; in_cur = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_zero_fill();
    t_sign_leak();
    t_invert();
    t_keep();
    t_narrow();
    t_illegal();
    t_idle();
    t_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule